// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Controller

This block is the hazard controller of a five-stage in-order pipeline made up of fetch, decode, execute, memory and writeback. Every instruction carries its destination register number and its write flag down the pipeline. The block compares the source register numbers of the instructions in decode, execute and memory with the destinations held in the later stage registers. From those comparisons it drives the select lines of the operand multiplexers, so that a result still in flight replaces a stale register value. Results are taken only from stage register outputs, never from the end of a stage's logic.

Three bypass paths are controlled. The memory stage register can feed either execute operand. The writeback stage register can feed either execute operand, and it can also feed the store-data input of the memory stage. The decode-stage register read also needs the value being written in the same cycle, so the block raises a read-bypass flag for each decode operand when its register is being written back. A loaded word only appears after the memory stage. An instruction in decode that needs the result of a load now in execute is therefore held for one cycle. During that cycle the fetch and decode registers freeze, a nop bubble goes into execute, and the load keeps moving forward. The block is purely combinational. It sits between the stage registers and the multiplexers they steer.

Top module: `fwd_hazard_ctl`

## Requirements
- R1: With every input at zero (an idle pipeline of nops), every output is zero.
- R2: An execute operand select (`exe_sel_a` for `exe_src_a`, `exe_sel_b` for `exe_src_b`) is 2'b10, meaning take the memory-stage result, when `mem_wr` is 1 and `mem_dst` is nonzero and equal to that source.
- R3: An execute operand select is 2'b01, meaning take the writeback-stage result, when `wb_wr` is 1 and `wb_dst` is nonzero and equal to that source, and R2 does not apply. Otherwise the select is 2'b00, meaning the value read at decode.
- R4: When the memory and writeback stages both hold an enabled write to the source register, the memory stage (the younger result) wins and the select is 2'b10.
- R5: Register 0 is never forwarded: a zero source gives select 2'b00 and no read bypass, and a zero destination never causes a stall.
- R6: A stage whose write flag is 0 is never used as a bypass source, whatever its destination number.
- R7: `mem_sel_st` is 1, meaning the store data comes from writeback, when `wb_wr` is 1 and `wb_dst` is nonzero and equal to `mem_src_st`, and 0 otherwise.
- R8: `dec_byp_a` / `dec_byp_b` is 1, meaning the decode read returns the writeback data, when `wb_wr` is 1 and `wb_dst` is nonzero and equal to `dec_src_a` / `dec_src_b`.
- R9: `hold_front` and `kill_exe` are both 1 exactly when execute holds a load (`exe_is_load` and `exe_wr` both 1) whose nonzero `exe_dst` equals either decode source. An ALU result in execute never stalls. A dependent instruction right after a load therefore sees exactly one bubble, and is then served by the writeback path.
- R10: An execute select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_src_a | input | AW | First source register of the instruction in decode |
| dec_src_b | input | AW | Second source register of the instruction in decode |
| exe_src_a | input | AW | First source register of the instruction in execute |
| exe_src_b | input | AW | Second source register of the instruction in execute |
| exe_dst | input | AW | Destination register of the instruction in execute |
| exe_wr | input | 1 | Instruction in execute writes a register |
| exe_is_load | input | 1 | Instruction in execute is a load |
| mem_src_st | input | AW | Store-data source register of the instruction in memory |
| mem_dst | input | AW | Destination register of the instruction in memory |
| mem_wr | input | 1 | Instruction in memory writes a register |
| wb_dst | input | AW | Destination register of the instruction in writeback |
| wb_wr | input | 1 | Instruction in writeback writes a register |
| exe_sel_a | output | 2 | Operand A select: 00 decode value, 01 writeback, 10 memory |
| exe_sel_b | output | 2 | Operand B select, same encoding |
| mem_sel_st | output | 1 | Store data taken from writeback |
| dec_byp_a | output | 1 | Decode read A returns the data being written back |
| dec_byp_b | output | 1 | Decode read B returns the data being written back |
| hold_front | output | 1 | Freeze the PC and the fetch/decode stage register |
| kill_exe | output | 1 | Load a nop bubble into the decode/execute stage register |

## Verification
Every output is a combinational function of the current stage-register fields, so every result is due in the same cycle as its stimulus. The bench applies each vector one time unit after a rising edge and samples half a period later, on the falling edge, before the next vector is applied. The load-use case is also walked over three consecutive cycles. In the first cycle a stall is expected. In the second, with the bubble in execute, no stall is expected. In the third, the writeback select for the dependent operand is expected. This confirms the single bubble.

// File: rtl/fwd_hazard_ctl.sv
module fwd_hazard_ctl #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic [AW-1:0] exe_src_a,
  input  logic [AW-1:0] exe_src_b,
  input  logic [AW-1:0] exe_dst,
  input  logic          exe_wr,
  input  logic          exe_is_load,
  input  logic [AW-1:0] mem_src_st,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic [1:0]    exe_sel_a,
  output logic [1:0]    exe_sel_b,
  output logic          mem_sel_st,
  output logic          dec_byp_a,
  output logic          dec_byp_b,
  output logic          hold_front,
  output logic          kill_exe
);
  localparam logic [AW-1:0] RZERO   = '0;
  localparam logic [1:0]    SEL_RF  = 2'b00;
  localparam logic [1:0]    SEL_WB  = 2'b01;
  localparam logic [1:0]    SEL_MEM = 2'b10;

  logic mem_live, wb_live, ld_live;
  assign mem_live = mem_wr && (mem_dst != RZERO);
  assign wb_live  = wb_wr  && (wb_dst  != RZERO);
  assign ld_live  = exe_is_load && exe_wr && (exe_dst != RZERO);

  assign exe_sel_a = (mem_live && mem_dst == exe_src_a) ? SEL_MEM :
                     (wb_live  && wb_dst  == exe_src_a) ? SEL_WB  : SEL_RF;
  assign exe_sel_b = (mem_live && mem_dst == exe_src_b) ? SEL_MEM :
                     (wb_live  && wb_dst  == exe_src_b) ? SEL_WB  : SEL_RF;

  assign mem_sel_st = wb_live && (wb_dst == mem_src_st);
  assign dec_byp_a  = wb_live && (wb_dst == dec_src_a);
  assign dec_byp_b  = wb_live && (wb_dst == dec_src_b);

  logic load_use;
  assign load_use   = ld_live && ((exe_dst == dec_src_a) || (exe_dst == dec_src_b));
  assign hold_front = load_use;
  assign kill_exe   = load_use;

  always_comb begin
    a_r10_sel_code: assert (exe_sel_a != 2'b11 && exe_sel_b != 2'b11);
    if (exe_sel_a == SEL_MEM)
      a_r2_mem_source: assert (mem_wr && mem_dst == exe_src_a);
    if (mem_wr && wb_wr && mem_dst == wb_dst && mem_dst == exe_src_b && mem_dst != RZERO)
      a_r4_younger_wins: assert (exe_sel_b == SEL_MEM);
    if (exe_src_a == RZERO)
      a_r5_zero_src: assert (exe_sel_a == SEL_RF);
    if (!mem_wr && !wb_wr)
      a_r6_disabled_src: assert (exe_sel_a == SEL_RF && exe_sel_b == SEL_RF && !mem_sel_st);
    if (!exe_is_load)
      a_r9_alu_no_stall: assert (!hold_front && !kill_exe);
    if (hold_front)
      a_r9_stall_bubble: assert (kill_exe);
  end
endmodule

// File: tb/tb_fwd_hazard_ctl.sv
module tb_fwd_hazard_ctl;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, exe_src_a = '0, exe_src_b = '0, exe_dst = '0;
  logic exe_wr = 1'b0, exe_is_load = 1'b0;
  logic [AW-1:0] mem_src_st = '0, mem_dst = '0, wb_dst = '0;
  logic mem_wr = 1'b0, wb_wr = 1'b0;
  logic [1:0] exe_sel_a, exe_sel_b;
  logic mem_sel_st, dec_byp_a, dec_byp_b, hold_front, kill_exe;

  fwd_hazard_ctl #(.AW(AW)) dut (
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .exe_src_a(exe_src_a), .exe_src_b(exe_src_b), .exe_dst(exe_dst),
    .exe_wr(exe_wr), .exe_is_load(exe_is_load),
    .mem_src_st(mem_src_st), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr),
    .exe_sel_a(exe_sel_a), .exe_sel_b(exe_sel_b), .mem_sel_st(mem_sel_st),
    .dec_byp_a(dec_byp_a), .dec_byp_b(dec_byp_b),
    .hold_front(hold_front), .kill_exe(kill_exe)
  );

  typedef struct packed {
    logic [4:0] da, db, ea, eb, ed;
    logic       ew, el;
    logic [4:0] ms, md;
    logic       mw;
    logic [4:0] wd;
    logic       ww;
    logic [8:0] exp;  // {sel_a, sel_b, st, byp_a, byp_b, hold, kill}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{5'd0, 5'd0, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0, 5'd0,  5'd3, 1'b1, 5'd0,  1'b0, 9'b10_00_00000, 4'd2}, // R2 operand A
    '{5'd0, 5'd0, 5'd1, 5'd7, 5'd0, 1'b0, 1'b0, 5'd0,  5'd7, 1'b1, 5'd0,  1'b0, 9'b00_10_00000, 4'd2}, // R2 operand B
    '{5'd0, 5'd0, 5'd9, 5'd2, 5'd0, 1'b0, 1'b0, 5'd0,  5'd0, 1'b0, 5'd9,  1'b1, 9'b01_00_00000, 4'd3}, // R3
    '{5'd0, 5'd0, 5'd5, 5'd5, 5'd0, 1'b0, 1'b0, 5'd0,  5'd5, 1'b1, 5'd5,  1'b1, 9'b10_10_00000, 4'd4}, // R4 priority
    '{5'd0, 5'd0, 5'd8, 5'd6, 5'd0, 1'b0, 1'b0, 5'd0,  5'd8, 1'b1, 5'd6,  1'b1, 9'b10_01_00000, 4'd4}, // R4 mixed
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0,  5'd0, 1'b1, 5'd0,  1'b1, 9'b00_00_00000, 4'd5}, // R5
    '{5'd0, 5'd0, 5'd3, 5'd3, 5'd0, 1'b0, 1'b0, 5'd0,  5'd3, 1'b0, 5'd3,  1'b0, 9'b00_00_00000, 4'd6}, // R6
    '{5'd0, 5'd0, 5'd3, 5'd1, 5'd0, 1'b0, 1'b0, 5'd0,  5'd3, 1'b0, 5'd3,  1'b1, 9'b01_00_00000, 4'd6}, // R6 mem off
    '{5'd0, 5'd11,5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd11, 5'd0, 1'b0, 5'd11, 1'b1, 9'b00_00_10100, 4'd7}, // R7
    '{5'd12,5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  5'd0, 1'b0, 5'd12, 1'b1, 9'b00_00_01000, 4'd8}, // R8
    '{5'd4, 5'd0, 5'd0, 5'd0, 5'd4, 1'b1, 1'b1, 5'd0,  5'd0, 1'b0, 5'd0,  1'b0, 9'b00_00_00011, 4'd9}, // R9 src A
    '{5'd0, 5'd4, 5'd0, 5'd0, 5'd4, 1'b1, 1'b1, 5'd0,  5'd0, 1'b0, 5'd0,  1'b0, 9'b00_00_00011, 4'd9}, // R9 src B
    '{5'd4, 5'd0, 5'd0, 5'd0, 5'd4, 1'b1, 1'b0, 5'd0,  5'd0, 1'b0, 5'd0,  1'b0, 9'b00_00_00000, 4'd9}, // R9 ALU
    '{5'd5, 5'd6, 5'd0, 5'd0, 5'd4, 1'b1, 1'b1, 5'd0,  5'd0, 1'b0, 5'd0,  1'b0, 9'b00_00_00000, 4'd9}, // R9 no match
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd11, 5'd0, 1'b0, 5'd11, 1'b0, 9'b00_00_00000, 4'd7}  // R7 wb off
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [8:0] outs();
    return {exe_sel_a, exe_sel_b, mem_sel_st, dec_byp_a, dec_byp_b, hold_front, kill_exe};
  endfunction

  task automatic apply(input vec_t v);
    @(posedge clk); #1;
    dec_src_a = v.da; dec_src_b = v.db; exe_src_a = v.ea; exe_src_b = v.eb;
    exe_dst = v.ed; exe_wr = v.ew; exe_is_load = v.el;
    mem_src_st = v.ms; mem_dst = v.md; mem_wr = v.mw;
    wb_dst = v.wd; wb_wr = v.ww;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [8:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, outs(), exp);
    end
  endtask

  initial begin
    @(negedge clk);
    check("R1 idle", 9'b0);  // R1
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
    end
    // R5: zero decode source with a live wb write of reg 0
    apply('{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 9'b0, 4'd5});
    check("R5 no read bypass of r0", 9'b0);
    // R9 and R3: load r4 then dependent, walked over three cycles
    apply('{5'd4, 5'd0, 5'd0, 5'd0, 5'd4, 1'b1, 1'b1, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 9'b0, 4'd9});
    check("R9 cycle1 stall", 9'b00_00_00011);
    apply('{5'd4, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b1, 5'd0, 1'b0, 9'b0, 4'd9});
    check("R9 cycle2 bubble in execute, no stall", 9'b00_00_00000);
    apply('{5'd0, 5'd0, 5'd4, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 5'd4, 1'b1, 9'b0, 4'd3});
    check("R3 cycle3 writeback feeds dependent", 9'b01_00_00000);
    // R10: select code 11 never seen across a full match set
    apply('{5'd7, 5'd7, 5'd7, 5'd7, 5'd0, 1'b0, 1'b0, 5'd7, 5'd7, 1'b1, 5'd7, 1'b1, 9'b0, 4'd10});
    check("R10 both selects memory, store and reads bypass", 9'b10_10_11100);
    // R1: back to idle
    apply('{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 9'b0, 4'd1});
    check("R1 idle again", 9'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule